// File: doc/BRIEF.md
# Flash command timing sequencer

This block sequences program and erase operations on an on-chip nonvolatile array. A CPU first writes data to an array address, which the block latches. It then writes a command code and sets a launch bit. The block then holds one enable strobe toward a behavioural array for a fixed number of slow timing ticks. The tick is a clock-enable pulse taken from the bus clock through a divider. The divider may be written only once after reset.

Badly ordered sequences raise an access-error flag, which returns the sequence to idle. While the flag is set it blocks further sequence writes and the divider write. Software clears it by writing 1.

Top module: `flash_cmd_seq`

## Requirements
- R1: A launch while the divider has never been written does not start a command; it sets `acc_err_o`, and `busy_o` stays low.
- R2: The divider (register select 0, value in `reg_wdata_i[5:0]`) takes only the first accepted write after reset, which raises `div_set_o`; later divider writes leave `div_val_o` unchanged.
- R3: A divider write while `acc_err_o` is high is ignored (`div_set_o` stays low).
- R4: Timing ticks occur every DIV+1 bus cycles, counted from the cycle after launch, so a command that needs N ticks holds `busy_o` high for exactly N*(DIV+1) cycles.
- R5: Tick counts per command code (register select 1): 0x11 byte program 9, 0x12 burst program 4, 0x21 page erase 4000, 0x22 mass erase 20000.
- R6: An array write (`arr_we_i`) latches address and data and must come first. A command write with nothing latched, a command write with an unknown code, a launch with no command, or an array write after the command all set `acc_err_o` and return to idle.
- R7: While busy, exactly one of `prog_en_o`, `page_erase_en_o`, `mass_erase_en_o` is high, and it matches the command. A program drives the latched address and data; with no command running, no strobe is high.
- R8: A page erase drives the latched address with its low 9 bits (512-byte page) cleared. A mass erase drives address 0. Both drive data 0xFF, whatever value was latched.
- R9: Writing register select 2 with bit 4 set clears `acc_err_o` and returns to idle, and launch is ignored in that write. While the flag is set, array, command and launch writes have no effect.
- R10: After reset, `div_set_o`, `busy_o`, `done_o` and `acc_err_o` are 0. `done_o` rises when a command ends and clears on the next launch.
- R11: Array, command and launch writes made while busy are ignored. The latch keeps the launched address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | 0 divider, 1 command, 2 control (bit 7 launch, bit 4 clear error) |
| reg_wdata_i | input | 8 | Register write data |
| arr_we_i | input | 1 | Array write strobe (sequence start) |
| arr_addr_i | input | ADDR_W | Array write address |
| arr_data_i | input | DATA_W | Array write data |
| div_set_o | output | 1 | Divider has been written |
| div_val_o | output | DIV_W | Divider value |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | Last command completed |
| acc_err_o | output | 1 | Access error flag |
| prog_en_o | output | 1 | Program strobe to array |
| page_erase_en_o | output | 1 | Page erase strobe to array |
| mass_erase_en_o | output | 1 | Mass erase strobe to array |
| mem_addr_o | output | ADDR_W | Address to array |
| mem_data_o | output | DATA_W | Data to array |

## Verification
The assertions check on every cycle that only one strobe is high while busy and none outside it, that a run never starts without a divider, and that the divider never changes once set. They also check that the error flag never coexists with a run, that done rises as busy falls and clears on launch, and that the array address holds steady during a run. The exact run length of each command, the ordering errors, clearing the error, and the addresses and data driven for erase can only be shown by the bench's scenarios. The bench checks these against its cycle-by-cycle model.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  localparam logic [1:0] SEL_DIV = 2'd0;
  localparam logic [1:0] SEL_CMD = 2'd1;
  localparam logic [1:0] SEL_CTL = 2'd2;
  localparam int GO_BIT  = 7;
  localparam int CLR_BIT = 4;

  typedef enum logic [7:0] {
    CMD_PROG  = 8'h11,
    CMD_BURST = 8'h12,
    CMD_PAGE  = 8'h21,
    CMD_MASS  = 8'h22
  } cmd_e;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_LATCHED = 2'd1,
    PH_ARMED   = 2'd2
  } phase_e;

  function automatic logic is_valid_cmd(input logic [7:0] code);
    return code inside {CMD_PROG, CMD_BURST, CMD_PAGE, CMD_MASS};
  endfunction
endpackage

// File: rtl/flash_tick_gen.sv
module flash_tick_gen #(
  parameter int DIV_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  // phase restarts at every launch so run length is exact
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!run_i)        cnt_q <= '0;
    else if (cnt_q == div_i) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = run_i && (cnt_q == div_i);
endmodule

// File: rtl/flash_cmd_timer.sv
module flash_cmd_timer #(
  parameter int CNT_W = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] ticks_i,
  input  logic             tick_i,
  output logic             busy_o,
  output logic             fin_o
);
  logic [CNT_W-1:0] rem_q;
  logic             busy_q;

  assign fin_o  = busy_q && tick_i && (rem_q == CNT_W'(1));
  assign busy_o = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      rem_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      rem_q  <= ticks_i;
    end else if (busy_q && tick_i) begin
      rem_q <= rem_q - 1'b1;
      if (fin_o) busy_q <= 1'b0;
    end
  end
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W     = 14,
  parameter int DATA_W     = 8,
  parameter int DIV_W      = 6,
  parameter int PAGE_BYTES = 512,
  parameter int PROG_TICKS  = 9,
  parameter int BURST_TICKS = 4,
  parameter int PAGE_TICKS  = 4000,
  parameter int MASS_TICKS  = 20000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_sel_i,
  input  logic [7:0]        reg_wdata_i,
  input  logic              arr_we_i,
  input  logic [ADDR_W-1:0] arr_addr_i,
  input  logic [DATA_W-1:0] arr_data_i,
  output logic              div_set_o,
  output logic [DIV_W-1:0]  div_val_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              acc_err_o,
  output logic              prog_en_o,
  output logic              page_erase_en_o,
  output logic              mass_erase_en_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_data_o
);
  localparam int PAGE_LSB = $clog2(PAGE_BYTES);
  localparam int CNT_W    = $clog2(MASS_TICKS + 1);

  logic [DIV_W-1:0]  div_q;
  logic              div_set_q, err_q, done_q;
  phase_e            phase_q;
  cmd_e              cmd_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              busy, tick, fin;
  logic              div_wr, cmd_wr, ctl_wr, launch_ok;
  logic [CNT_W-1:0]  ticks;

  assign div_wr = reg_we_i && (reg_sel_i == SEL_DIV);
  assign cmd_wr = reg_we_i && (reg_sel_i == SEL_CMD);
  assign ctl_wr = reg_we_i && (reg_sel_i == SEL_CTL);
  assign launch_ok = ctl_wr && reg_wdata_i[GO_BIT] && !reg_wdata_i[CLR_BIT] && !err_q
                     && !busy && (phase_q == PH_ARMED) && div_set_q;

  always_comb begin
    case (cmd_q)
      CMD_BURST: ticks = CNT_W'(BURST_TICKS);
      CMD_PAGE:  ticks = CNT_W'(PAGE_TICKS);
      CMD_MASS:  ticks = CNT_W'(MASS_TICKS);
      default:   ticks = CNT_W'(PROG_TICKS);
    endcase
  end

  flash_tick_gen #(.DIV_W(DIV_W)) tick_i (
    .clk_i, .rst_ni, .run_i(busy), .div_i(div_q), .tick_o(tick)
  );

  flash_cmd_timer #(.CNT_W(CNT_W)) timer_i (
    .clk_i, .rst_ni, .start_i(launch_ok), .ticks_i(ticks), .tick_i(tick),
    .busy_o(busy), .fin_o(fin)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q     <= '0;
      div_set_q <= 1'b0;
      err_q     <= 1'b0;
      done_q    <= 1'b0;
      phase_q   <= PH_IDLE;
      cmd_q     <= CMD_PROG;
      addr_q    <= '0;
      data_q    <= '0;
    end else begin
      if (div_wr && !div_set_q && !err_q) begin
        div_q     <= reg_wdata_i[DIV_W-1:0];
        div_set_q <= 1'b1;
      end
      if (!busy) begin
        if (arr_we_i && !err_q) begin
          if (phase_q == PH_ARMED) begin
            err_q   <= 1'b1;
            phase_q <= PH_IDLE;
          end else begin
            addr_q  <= arr_addr_i;
            data_q  <= arr_data_i;
            phase_q <= PH_LATCHED;
          end
        end
        if (cmd_wr && !err_q) begin
          if (phase_q == PH_LATCHED && is_valid_cmd(reg_wdata_i)) begin
            cmd_q   <= cmd_e'(reg_wdata_i);
            phase_q <= PH_ARMED;
          end else begin
            err_q   <= 1'b1;
            phase_q <= PH_IDLE;
          end
        end
        if (ctl_wr) begin
          if (reg_wdata_i[CLR_BIT]) begin
            err_q   <= 1'b0;
            phase_q <= PH_IDLE;
          end else if (reg_wdata_i[GO_BIT] && !err_q) begin
            if (!launch_ok) err_q <= 1'b1;
            phase_q <= PH_IDLE;
          end
        end
      end
      if (launch_ok) done_q <= 1'b0;
      else if (fin)  done_q <= 1'b1;
    end
  end

  always_comb begin
    mem_addr_o = addr_q;
    mem_data_o = data_q;
    if (busy) begin
      case (cmd_q)
        CMD_PAGE: begin
          mem_addr_o = {addr_q[ADDR_W-1:PAGE_LSB], {PAGE_LSB{1'b0}}};
          mem_data_o = '1;
        end
        CMD_MASS: begin
          mem_addr_o = '0;
          mem_data_o = '1;
        end
        default: ;
      endcase
    end
  end

  assign div_set_o       = div_set_q;
  assign div_val_o       = div_q;
  assign busy_o          = busy;
  assign done_o          = done_q;
  assign acc_err_o       = err_q;
  assign prog_en_o       = busy && (cmd_q == CMD_PROG || cmd_q == CMD_BURST);
  assign page_erase_en_o = busy && (cmd_q == CMD_PAGE);
  assign mass_erase_en_o = busy && (cmd_q == CMD_MASS);
endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk #(
  parameter int DIV_W  = 6,
  parameter int ADDR_W = 14
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_o,
  input logic              done_o,
  input logic              acc_err_o,
  input logic              div_set_o,
  input logic [DIV_W-1:0]  div_val_o,
  input logic              prog_en_o,
  input logic              page_erase_en_o,
  input logic              mass_erase_en_o,
  input logic [ADDR_W-1:0] mem_addr_o
);
  a_r1_busy_needs_div: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> div_set_o);

  a_r2_div_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_set_o |=> (div_set_o && $stable(div_val_o)));

  a_r3_err_blocks_div: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_err_o && !div_set_o) |=> !div_set_o);

  a_r7_one_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> ($countones({prog_en_o, page_erase_en_o, mass_erase_en_o}) == 1));

  a_r7_no_idle_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !(prog_en_o || page_erase_en_o || mass_erase_en_o));

  a_r9_no_err_in_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !acc_err_o);

  a_r10_done_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  a_r10_done_clr_launch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> !done_o);

  a_r11_addr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(mem_addr_o));
endmodule

bind flash_cmd_seq flash_cmd_seq_chk #(.DIV_W(DIV_W), .ADDR_W(ADDR_W)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_o(busy_o), .done_o(done_o),
  .acc_err_o(acc_err_o), .div_set_o(div_set_o), .div_val_o(div_val_o),
  .prog_en_o(prog_en_o), .page_erase_en_o(page_erase_en_o),
  .mass_erase_en_o(mass_erase_en_o), .mem_addr_o(mem_addr_o)
);

// File: tb/flash_cmd_seq_tb_top.sv
module flash_cmd_seq_tb_top;
  localparam int AW = 14;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [1:0] reg_sel = '0;
  logic [7:0] reg_wdata = '0;
  logic arr_we = 1'b0;
  logic [AW-1:0] arr_addr = '0;
  logic [DW-1:0] arr_data = '0;
  logic div_set, busy, done, err, p_en, pg_en, ms_en;
  logic [5:0] div_val;
  logic [AW-1:0] m_addr;
  logic [DW-1:0] m_data;

  always #2.5 clk = ~clk;

  flash_cmd_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_sel_i(reg_sel),
    .reg_wdata_i(reg_wdata), .arr_we_i(arr_we), .arr_addr_i(arr_addr),
    .arr_data_i(arr_data), .div_set_o(div_set), .div_val_o(div_val),
    .busy_o(busy), .done_o(done), .acc_err_o(err), .prog_en_o(p_en),
    .page_erase_en_o(pg_en), .mass_erase_en_o(ms_en),
    .mem_addr_o(m_addr), .mem_data_o(m_data)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit finished = 0;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // behavioural reference model
  bit m_div_set, m_err, m_done, m_busy;
  int m_div, m_phase, m_cmd, m_left;
  int m_la, m_ld;

  function automatic int ticks_of(input int c);
    case (c)
      8'h11: return 9;
      8'h12: return 4;
      8'h21: return 4000;
      default: return 20000;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_div_set = 0; m_err = 0; m_done = 0; m_busy = 0;
      m_div = 0; m_phase = 0; m_cmd = 8'h11; m_left = 0; m_la = 0; m_ld = 0;
    end else if (m_busy) begin
      m_left--;
      if (m_left == 0) begin m_busy = 0; m_done = 1; end
    end else begin
      if (arr_we && !m_err) begin
        if (m_phase == 2) begin m_err = 1; m_phase = 0; end
        else begin m_la = arr_addr; m_ld = arr_data; m_phase = 1; end
      end
      if (reg_we) begin
        if (reg_sel == 0 && !m_div_set && !m_err) begin
          m_div = reg_wdata[5:0]; m_div_set = 1;
        end else if (reg_sel == 1 && !m_err) begin
          if (m_phase == 1 && (reg_wdata == 8'h11 || reg_wdata == 8'h12 ||
                               reg_wdata == 8'h21 || reg_wdata == 8'h22)) begin
            m_cmd = reg_wdata; m_phase = 2;
          end else begin m_err = 1; m_phase = 0; end
        end else if (reg_sel == 2) begin
          if (reg_wdata[4]) begin m_err = 0; m_phase = 0; end
          else if (reg_wdata[7] && !m_err) begin
            if (m_phase == 2 && m_div_set) begin
              m_busy = 1; m_done = 0; m_left = ticks_of(m_cmd) * (m_div + 1);
            end else m_err = 1;
            m_phase = 0;
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      int ea, ed;
      ea = m_la; ed = m_ld;
      if (m_busy && m_cmd == 8'h21) begin ea = m_la & ~32'h1FF; ed = 8'hFF; end
      if (m_busy && m_cmd == 8'h22) begin ea = 0; ed = 8'hFF; end
      chk("R4 R5", "busy", busy, m_busy);
      chk("R10", "done", done, m_done);
      chk("R6", "acc_err", err, m_err);
      chk("R2", "div_set", div_set, m_div_set);
      chk("R2", "div_val", div_val, m_div);
      chk("R7", "prog_en", p_en, m_busy && (m_cmd == 8'h11 || m_cmd == 8'h12));
      chk("R7", "page_en", pg_en, m_busy && m_cmd == 8'h21);
      chk("R7", "mass_en", ms_en, m_busy && m_cmd == 8'h22);
      chk("R8", "mem_addr", m_addr, ea);
      chk("R8", "mem_data", m_data, ed);
    end
  end

  task automatic reg_wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk); reg_we = 1; reg_sel = sel; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic arr_wr(input int a, input int d);
    @(negedge clk); arr_we = 1; arr_addr = AW'(a); arr_data = DW'(d);
    @(negedge clk); arr_we = 0;
  endtask

  // launch and measure run length in bus cycles
  task automatic run_cmd(input int a, input int d, input logic [7:0] c, output int len);
    arr_wr(a, d);
    reg_wr(2'd1, c);
    @(negedge clk); reg_we = 1; reg_sel = 2'd2; reg_wdata = 8'h80;
    @(negedge clk); reg_we = 0;
    len = 0;
    while (busy) begin len++; @(negedge clk); end
  endtask

  task automatic summary();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      summary();
    end
  end

  initial begin
    int len;
    repeat (3) @(negedge clk);
    chk("R10", "reset busy", busy, 0);
    chk("R10", "reset err", err, 0);
    chk("R10", "reset div_set", div_set, 0);
    rst_n = 1;
    @(negedge clk);
    // R1: launch with no divider
    arr_wr(14'h0100, 8'h3C);
    reg_wr(2'd1, 8'h11);
    reg_wr(2'd2, 8'h80);
    chk("R1", "err after undivided launch", err, 1);
    chk("R1", "busy after undivided launch", busy, 0);
    // R3: divider write blocked by error
    reg_wr(2'd0, 8'd7);
    chk("R3", "div_set while err", div_set, 0);
    // R9: array write ignored while err
    arr_wr(14'h2222, 8'h55);
    chk("R9", "latch untouched while err", m_addr, 14'h0100);
    reg_wr(2'd2, 8'h10);
    chk("R9", "err cleared", err, 0);
    // R2: write once
    reg_wr(2'd0, 8'd2);
    reg_wr(2'd0, 8'd5);
    chk("R2", "div kept first value", div_val, 2);
    // R5 program / burst
    run_cmd(14'h1234, 8'hA5, 8'h11, len);
    chk("R5", "program cycles", len, 27);
    chk("R10", "done after program", done, 1);
    chk("R7", "program latched data", m_data, 8'hA5);
    run_cmd(14'h0042, 8'h5A, 8'h12, len);
    chk("R5", "burst cycles", len, 12);
    // R6 ordering errors
    reg_wr(2'd1, 8'h21);
    chk("R6", "cmd before latch", err, 1);
    reg_wr(2'd2, 8'h10);
    arr_wr(14'h0300, 8'h01);
    reg_wr(2'd2, 8'h80);
    chk("R6", "launch before cmd", err, 1);
    reg_wr(2'd2, 8'h10);
    arr_wr(14'h0300, 8'h01);
    reg_wr(2'd1, 8'h99);
    chk("R6", "unknown code", err, 1);
    reg_wr(2'd2, 8'h10);
    arr_wr(14'h0300, 8'h01);
    reg_wr(2'd1, 8'h11);
    arr_wr(14'h0301, 8'h02);
    chk("R6", "array write after cmd", err, 1);
    reg_wr(2'd2, 8'h90);
    chk("R9", "clear wins over launch", busy, 0);
    // R8 page erase, R11 writes during run ignored
    arr_wr(14'h0BCD, 8'h77);
    reg_wr(2'd1, 8'h21);
    reg_wr(2'd2, 8'h80);
    chk("R8", "page base addr", m_addr, 14'h0A00);
    chk("R8", "page erase data", m_data, 8'hFF);
    arr_wr(14'h0000, 8'h00);
    reg_wr(2'd1, 8'h22);
    reg_wr(2'd2, 8'h80);
    len = 6;
    while (busy) begin len++; @(negedge clk); end
    chk("R5", "page erase cycles", len, 12000);
    chk("R11", "latch kept after run", m_addr, 14'h0BCD);
    chk("R11", "no error from run writes", err, 0);
    // mass erase
    run_cmd(14'h1FFF, 8'h12, 8'h22, len);
    chk("R5", "mass erase cycles", len, 60000);
    chk("R10", "done after mass", done, 1);
    chk("R8", "latch after mass", m_addr, 14'h1FFF);
    summary();
  end
endmodule